// File: doc/BRIEF.md
# Up/Down Event Counter with Control and Status Register

This block is one counter channel. It counts single-cycle up and down pulses in a parameterised register that is eight bits wide by default. When the count runs past either end of its range, it reloads from a value supplied on an input port. When the count reaches a value supplied on a second input port, the block records a compare match.

One 8-bit control and status register holds the configuration and the state. It has three control bits: run, compare-interrupt enable and wrap-interrupt enable. It has three sticky event flags: compare match, overflow and underflow. It also has a two-bit read-only field that shows the direction of the last counted pulse. One interrupt request line combines the flags with their enables.

Software uses a plain synchronous port to reach the register. A write strobe with write data updates the register on the clock edge. The read data always shows the current register contents. The count pulses are single-cycle strobes, not a data stream, so there is no valid/ready handshake and no back-pressure. A pulse is either counted in its cycle or ignored. The current count is always visible on its own output.

Top module: `udc_channel`

## Requirements
- R1: A synchronous active-high reset sets the register to 0x00 (stopped, interrupts disabled, flags clear, direction 00), sets the count to 0 and drives the interrupt line low.
- R2: Register bit 7 (run) gates counting. A pulse is counted only while the stored run bit is 1, so a write that changes run takes effect from the next cycle. While run is 0, the count, flags and direction do not change.
- R3: A counted up pulse adds one to the count, and a counted down pulse subtracts one. The new count appears on `count_o` after the clock edge on which the pulse is sampled.
- R4: A counted up pulse at the all-ones count loads the reload input into the count instead of wrapping to zero, and sets the overflow flag, bit 3.
- R5: A counted down pulse at count zero loads the reload input into the count, and sets the underflow flag, bit 2.
- R6: The compare flag, bit 4, is set on the edge where a counted pulse makes the count equal to the compare input. This includes a wrap whose reload value equals the compare input.
- R7: Flags are sticky. A register write with 0 in a flag bit clears that flag. A write with 1 leaves the flag as it is and never sets it. A hardware event in the same cycle as a clearing write leaves the flag set.
- R8: Bits 1:0 read 00 before any counted pulse, 01 after a counted down pulse and 10 after a counted up pulse. Writes to these bits have no effect.
- R9: Up and down pulses in the same cycle cancel each other: the count, the flags and the direction stay unchanged.
- R10: The interrupt line is high exactly when either of two conditions holds. The first is that the compare flag is set and compare-interrupt enable (bit 6) is set. The second is that the overflow or underflow flag is set and wrap-interrupt enable (bit 5) is set. A flag whose enable is clear still records its event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_up_i | input | 1 | Single-cycle up count pulse |
| cnt_dn_i | input | 1 | Single-cycle down count pulse |
| cmp_val_i | input | WIDTH | Compare value |
| rld_val_i | input | WIDTH | Value loaded on overflow or underflow |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register contents {run, cmp_ie, wrap_ie, cmpf, ovf, udf, dir[1:0]} |
| count_o | output | WIDTH | Current count |
| irq_o | output | 1 | Interrupt request |

## Verification
The counter is driven with several input patterns:
- Runs of up pulses and runs of down pulses, which separate plain stepping from the two wrap paths and show the direction field changing.
- Simultaneous up and down pulses, which show that the pulses cancel and do not take a priority order.
- Pulses while the channel is stopped, and in the cycle where run is written, which show the one-cycle latency of the run bit.

Register writes that coincide with events cover the rule that a hardware set wins over a clear, writing 1 to a flag and writing to the direction bits. A reload value equal to the compare value shows that a wrap also counts as a compare match. The enables are toggled to show that flags still record events while the interrupt line stays low.

// File: rtl/udc_pkg.sv
package udc_pkg;
  localparam int REG_W      = 8;
  localparam int BIT_RUN    = 7;
  localparam int BIT_CMPIE  = 6;
  localparam int BIT_WRAPIE = 5;
  localparam int BIT_CMPF   = 4;
  localparam int BIT_OVF    = 3;
  localparam int BIT_UDF    = 2;
  localparam int NUM_FLAGS  = 3;
  localparam int FLAG_LSB   = BIT_UDF;

  typedef enum logic [1:0] {
    DIR_NONE = 2'b00,
    DIR_DOWN = 2'b01,
    DIR_UP   = 2'b10
  } dir_e;

  // packed so that bit 2 = compare, bit 1 = overflow, bit 0 = underflow
  typedef struct packed {
    logic cmp;
    logic ovf;
    logic udf;
  } evt_t;

  typedef struct packed {
    logic run;
    logic cmp_ie;
    logic wrap_ie;
  } ctrl_t;
endpackage

// File: rtl/udc_step.sv
module udc_step
  import udc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             run,
  input  logic             up,
  input  logic             down,
  input  logic [WIDTH-1:0] cnt,
  input  logic [WIDTH-1:0] cmp_val,
  input  logic [WIDTH-1:0] rld_val,
  output logic [WIDTH-1:0] cnt_nxt,
  output logic             counted,
  output dir_e             dir_nxt,
  output evt_t             evt
);
  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] CNT_MIN = '0;
  localparam logic [WIDTH-1:0] ONE     = {{(WIDTH-1){1'b0}}, 1'b1};

  logic step_up, step_dn;

  always_comb begin
    step_up = run & up & ~down;
    step_dn = run & down & ~up;
    cnt_nxt = cnt;
    evt     = '0;
    if (step_up) begin
      if (cnt == CNT_MAX) begin
        cnt_nxt = rld_val;
        evt.ovf = 1'b1;
      end else begin
        cnt_nxt = cnt + ONE;
      end
    end else if (step_dn) begin
      if (cnt == CNT_MIN) begin
        cnt_nxt = rld_val;
        evt.udf = 1'b1;
      end else begin
        cnt_nxt = cnt - ONE;
      end
    end
    counted = step_up | step_dn;
    evt.cmp = counted & (cnt_nxt == cmp_val);
    dir_nxt = step_up ? DIR_UP : DIR_DOWN;
  end
endmodule

// File: rtl/udc_count_reg.sv
module udc_count_reg
  import udc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             counted,
  input  logic [WIDTH-1:0] cnt_nxt,
  input  dir_e             dir_nxt,
  output logic [WIDTH-1:0] cnt_q,
  output dir_e             dir_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dir_q <= DIR_NONE;
    end else if (counted) begin
      cnt_q <= cnt_nxt;
      dir_q <= dir_nxt;
    end
  end
endmodule

// File: rtl/udc_status_reg.sv
module udc_status_reg
  import udc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [REG_W-1:FLAG_LSB] wr_data,
  input  evt_t                   evt,
  output ctrl_t                  ctrl_q,
  output logic [NUM_FLAGS-1:0]   flag_q
);
  logic [NUM_FLAGS-1:0] hw_set;
  assign hw_set = evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q.run     <= wr_data[BIT_RUN];
      ctrl_q.cmp_ie  <= wr_data[BIT_CMPIE];
      ctrl_q.wrap_ie <= wr_data[BIT_WRAPIE];
    end
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic keep;
    assign keep = ~wr_en | wr_data[FLAG_LSB + i];
    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= hw_set[i] | (flag_q[i] & keep);
    end
  end
endmodule

// File: rtl/udc_channel.sv
module udc_channel
  import udc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_up_i,
  input  logic             cnt_dn_i,
  input  logic [WIDTH-1:0] cmp_val_i,
  input  logic [WIDTH-1:0] rld_val_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic [WIDTH-1:0] count_o,
  output logic             irq_o
);
  logic [WIDTH-1:0]     cnt_q, cnt_nxt;
  logic                 counted;
  dir_e                 dir_q, dir_nxt;
  evt_t                 evt;
  ctrl_t                ctrl_q;
  logic [NUM_FLAGS-1:0] flag_q;
  logic                 unused_dir_wr;

  assign unused_dir_wr = ^reg_wdata_i[FLAG_LSB-1:0];

  udc_step #(.WIDTH(WIDTH)) u_step (
    .run     (ctrl_q.run),
    .up      (cnt_up_i),
    .down    (cnt_dn_i),
    .cnt     (cnt_q),
    .cmp_val (cmp_val_i),
    .rld_val (rld_val_i),
    .cnt_nxt (cnt_nxt),
    .counted (counted),
    .dir_nxt (dir_nxt),
    .evt     (evt)
  );

  udc_count_reg #(.WIDTH(WIDTH)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .counted (counted),
    .cnt_nxt (cnt_nxt),
    .dir_nxt (dir_nxt),
    .cnt_q   (cnt_q),
    .dir_q   (dir_q)
  );

  udc_status_reg u_stat (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_i),
    .wr_data (reg_wdata_i[REG_W-1:FLAG_LSB]),
    .evt     (evt),
    .ctrl_q  (ctrl_q),
    .flag_q  (flag_q)
  );

  assign reg_rdata_o = {ctrl_q.run, ctrl_q.cmp_ie, ctrl_q.wrap_ie, flag_q, dir_q};
  assign count_o     = cnt_q;
  assign irq_o       = (flag_q[2] & ctrl_q.cmp_ie) |
                       ((flag_q[1] | flag_q[0]) & ctrl_q.wrap_ie);
endmodule

// File: rtl/udc_channel_sva.sv
module udc_channel_sva #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_up_i,
  input logic             cnt_dn_i,
  input logic [WIDTH-1:0] rld_val_i,
  input logic             reg_wr_i,
  input logic [7:0]       reg_rdata_o,
  input logic [WIDTH-1:0] count_o,
  input logic             irq_o
);
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !reg_rdata_o[7] |=> $stable(count_o)); // R2
  AST_CANCEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (cnt_up_i && cnt_dn_i) |=> ($stable(count_o) && $stable(reg_rdata_o[1:0]))); // R9
  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata_o[7] && cnt_up_i && !cnt_dn_i && count_o == {WIDTH{1'b1}})
      |=> (count_o == $past(rld_val_i) && reg_rdata_o[3])); // R4
  AST_UDF_WRAP: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata_o[7] && cnt_dn_i && !cnt_up_i && count_o == '0)
      |=> (count_o == $past(rld_val_i) && reg_rdata_o[2])); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata_o[4] && !reg_wr_i) |=> reg_rdata_o[4]); // R7
  AST_DIR_LEGAL: assert property (@(posedge clk) disable iff (rst)
    reg_rdata_o[1:0] != 2'b11); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!reg_rdata_o[6] && !reg_rdata_o[5]) |-> !irq_o); // R10
endmodule

bind udc_channel udc_channel_sva #(.WIDTH(WIDTH)) u_sva (
  .clk         (clk),
  .rst         (rst),
  .cnt_up_i    (cnt_up_i),
  .cnt_dn_i    (cnt_dn_i),
  .rld_val_i   (rld_val_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rdata_o (reg_rdata_o),
  .count_o     (count_o),
  .irq_o       (irq_o)
);

// File: tb/udc_channel_tb.sv
module udc_channel_tb;
  localparam int W  = 8;
  localparam int NV = 21;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         up = 1'b0, dn = 1'b0, wr = 1'b0;
  logic [W-1:0] cmp = '0, rld = '0;
  logic [7:0]   wd = '0;
  logic [7:0]   rdata;
  logic [W-1:0] cnt;
  logic         irq;
  int           n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  udc_channel #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .cnt_up_i(up), .cnt_dn_i(dn),
    .cmp_val_i(cmp), .rld_val_i(rld), .reg_wr_i(wr), .reg_wdata_i(wd),
    .reg_rdata_o(rdata), .count_o(cnt), .irq_o(irq)
  );

  // {wr, wdata, up, dn, cmp, rld, exp_cnt, exp_stat, exp_irq}
  localparam logic [43:0] VEC [NV] = '{
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h03, 8'h00, 8'h00, 8'h00, 1'b0},
    {1'b1, 8'hE0, 1'b0, 1'b0, 8'h03, 8'h00, 8'h00, 8'hE0, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0, 8'h03, 8'h00, 8'h01, 8'hE2, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0, 8'h03, 8'h00, 8'h02, 8'hE2, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0, 8'h03, 8'h00, 8'h03, 8'hF2, 1'b1},
    {1'b0, 8'h00, 1'b1, 1'b1, 8'h03, 8'h00, 8'h03, 8'hF2, 1'b1},
    {1'b1, 8'hEF, 1'b0, 1'b0, 8'h03, 8'h00, 8'h03, 8'hE2, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b1, 8'h03, 8'h00, 8'h02, 8'hE1, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b1, 8'h03, 8'h00, 8'h01, 8'hE1, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b1, 8'h03, 8'h00, 8'h00, 8'hE1, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b1, 8'h03, 8'hFE, 8'hFE, 8'hE5, 1'b1},
    {1'b1, 8'h80, 1'b0, 1'b0, 8'hFF, 8'hFE, 8'hFE, 8'h81, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0, 8'hFF, 8'hFE, 8'hFF, 8'h92, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0, 8'hFF, 8'hFE, 8'hFE, 8'h9A, 1'b0},
    {1'b1, 8'hBC, 1'b0, 1'b0, 8'hFF, 8'hFE, 8'hFE, 8'hBA, 1'b1},
    {1'b1, 8'h00, 1'b0, 1'b0, 8'hFF, 8'hFE, 8'hFE, 8'h02, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0, 8'hFF, 8'hFE, 8'hFE, 8'h02, 1'b0},
    {1'b1, 8'h80, 1'b1, 1'b0, 8'hFF, 8'hFE, 8'hFE, 8'h82, 1'b0},
    {1'b1, 8'h80, 1'b1, 1'b0, 8'hFF, 8'hFE, 8'hFF, 8'h92, 1'b0},
    {1'b1, 8'hC0, 1'b1, 1'b0, 8'hFE, 8'hFE, 8'hFE, 8'hDA, 1'b1},
    {1'b0, 8'h00, 1'b0, 1'b1, 8'hFE, 8'hFE, 8'hFD, 8'hD9, 1'b1}
  };

  function automatic string tag_of(int i);
    case (i)
      0:                   return "R1";
      1, 15, 16, 17:       return "R2";
      2, 3, 8, 9:          return "R3";
      4, 19:               return "R6";
      5:                   return "R9";
      6, 11, 18:           return "R7";
      7, 20:               return "R8";
      10:                  return "R5";
      13:                  return "R4";
      default:             return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [W-1:0] ec, logic [7:0] es, logic ei);
    n_chk++;
    if (cnt !== ec || rdata !== es || irq !== ei) begin
      n_fail++;
      $display("FAIL %s: actual cnt=%h stat=%h irq=%b expected cnt=%h stat=%h irq=%b",
               req, cnt, rdata, irq, ec, es, ei);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL R1: watchdog expired, actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      wr  = VEC[i][43];
      wd  = VEC[i][42:35];
      up  = VEC[i][34];
      dn  = VEC[i][33];
      cmp = VEC[i][32:25];
      rld = VEC[i][24:17];
      cycle();
      check(tag_of(i), VEC[i][16:9], VEC[i][8:1], VEC[i][0]);
      @(negedge clk);
    end
    // R1: reset in the middle of a run with flags and irq active
    wr = 1'b0; up = 1'b0; dn = 1'b0; rst = 1'b1;
    cycle();
    check("R1", 8'h00, 8'h00, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    // R7 / R8: writing 1 to flags and to the direction bits sets nothing
    wr = 1'b1; wd = 8'h1F;
    cycle();
    check("R8", 8'h00, 8'h00, 1'b0);
    @(negedge clk);
    // R2: a stopped channel ignores a burst of down pulses
    wr = 1'b0; dn = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R2", 8'h00, 8'h00, 1'b0);
    @(negedge clk);
    dn = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule